// File: doc/BRIEF.md
# Issue Slot with Taint Wait State

This block is one entry of an out-of-order issue queue. It holds a single instruction, identified by its reorder-buffer (ROB) index, together with an opaque payload, and walks it through four scheduling states: EMPTY, READY, ISSUED and WAIT. An instruction enters through an allocation handshake. It requests issue while READY and stays allocated after issue until the execution side reports either completion or a security kill.

A security kill arrives when the information flow controller stops a tainted transmitter at the start of execution. The kill carries the ROB index of the stopped instruction and the ROB index of its youngest root of taint. The slot whose index matches keeps that root index and parks in WAIT. Every cycle it checks whether the stored root now lies strictly older than the visibility point. Age is measured from the ROB head, so the check holds across index wrap-around. Once the root is safe, the slot returns to READY and competes again through the ordinary scheduler, with no extra priority. A pipeline flush empties the slot from any state when its instruction is at or younger than the flush point.

Allocation is a valid/ready stream: `alloc_ready` is high only when the slot is empty and no flush is in progress, and a transfer happens on a cycle where both are high. The producer must hold its fields stable while `alloc_valid` waits. Issue is also valid/ready: `issue_valid` stays high with stable fields until the scheduler raises `issue_ready`, and the transfer happens on a cycle where both are high. Completion, kill, flush and the ROB pointers are plain single-cycle control pins.

Top module: `taint_issue_slot`

## Requirements
- R1: After reset the slot is EMPTY: `alloc_ready`=1, `issue_valid`=0, `slot_wait`=0.
- R2: An allocation handshake stores `alloc_rob_idx` and `alloc_payload`. From the next cycle `issue_valid`=1 with those values on `issue_rob_idx` and `issue_payload`.
- R3: `issue_valid` stays high with stable fields until `issue_ready` is high. After that transfer the slot is ISSUED, with `issue_valid`=0 and `alloc_ready`=0.
- R4: A `done_valid` in ISSUED whose `done_rob_idx` equals the stored index empties the slot on the next cycle. A non-matching completion has no effect.
- R5: A `kill_valid` in ISSUED whose `kill_rob_idx` equals the stored index latches `kill_yrot` and enters WAIT (`slot_wait`=1, `issue_valid`=0). A non-matching kill has no effect.
- R6: A root index y counts as safe when (y - `rob_head`) mod ROB_DEPTH < (`vis_ptr` - `rob_head`) mod ROB_DEPTH. A root equal in age to the visibility point is not safe.
- R7: A slot in WAIT holds its state and its stored root while the root is unsafe.
- R8: On the cycle after the stored root becomes safe, the slot is READY and requests issue again with its original index and payload.
- R9: If the supplied root is already safe in the cycle the kill arrives, the slot goes straight to READY and `slot_wait` never rises.
- R10: A `flush_valid` squashes the slot, from any state including WAIT, when the stored index is at or younger than `flush_rob_idx` (age measured from `rob_head`). The slot is EMPTY the next cycle. An older instruction stays untouched.
- R11: While `flush_valid` is high, `alloc_ready`=0 and no allocation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Slot can accept an instruction |
| alloc_rob_idx | input | IDX_W | ROB index of the allocated instruction |
| alloc_payload | input | PAYLOAD_W | Opaque instruction payload |
| issue_valid | output | 1 | Slot requests issue |
| issue_ready | input | 1 | Scheduler grant for this slot |
| issue_rob_idx | output | IDX_W | ROB index of the held instruction |
| issue_payload | output | PAYLOAD_W | Payload of the held instruction |
| done_valid | input | 1 | Execution completion pulse |
| done_rob_idx | input | IDX_W | ROB index that completed |
| kill_valid | input | 1 | Flow-controller kill/wait pulse |
| kill_rob_idx | input | IDX_W | ROB index of the killed instruction |
| kill_yrot | input | IDX_W | ROB index of its youngest root of taint |
| rob_head | input | IDX_W | Oldest ROB entry |
| vis_ptr | input | IDX_W | First ROB entry not yet past the visibility point |
| flush_valid | input | 1 | Pipeline flush pulse |
| flush_rob_idx | input | IDX_W | Oldest squashed ROB index |
| slot_wait | output | 1 | Slot is parked waiting for its root of taint |

## Verification
The bench builds the slot with ROB_DEPTH=16 and PAYLOAD_W=32. A power-of-two depth selects the modular-subtraction age path. Sixteen entries let the head sit at 14 while the visibility point and the roots sit at 1, 2 and 15, which exercises the safe check and the flush comparison across index wrap-around. A 32-bit payload lets each issued instruction carry a distinct marker, so the scoreboard can tell a re-issue after WAIT apart from a fresh allocation.

// File: rtl/tw_slot_pkg.sv
package tw_slot_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY  = 2'd0,
    SLOT_READY  = 2'd1,
    SLOT_ISSUED = 2'd2,
    SLOT_WAIT   = 2'd3
  } slot_state_e;
endpackage

// File: rtl/tw_rob_age.sv
// Distance of a ROB index from the head, modulo the ROB depth.
module tw_rob_age #(
  parameter int ROB_DEPTH = 16,
  localparam int IDX_W = $clog2(ROB_DEPTH)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] age
);
  localparam bit POW2 = ((ROB_DEPTH & (ROB_DEPTH - 1)) == 0);

  generate
    if (POW2) begin : g_pow2
      // Natural wrap of the index width equals the ROB modulus.
      assign age = idx - head;
    end else begin : g_nonpow2
      localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(ROB_DEPTH);
      always_comb begin
        if (idx >= head) age = idx - head;
        else             age = idx - head + DEPTH_V;
      end
    end
  endgenerate
endmodule

// File: rtl/tw_yrot_safe.sv
// A root of taint is safe once it is strictly older than the visibility point.
module tw_yrot_safe #(
  parameter int ROB_DEPTH = 16,
  localparam int IDX_W = $clog2(ROB_DEPTH)
) (
  input  logic [IDX_W-1:0] yrot,
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] vis,
  output logic             safe
);
  logic [IDX_W-1:0] yrot_age;
  logic [IDX_W-1:0] vis_age;

  tw_rob_age #(.ROB_DEPTH(ROB_DEPTH)) u_age_root (.idx(yrot), .head(head), .age(yrot_age));
  tw_rob_age #(.ROB_DEPTH(ROB_DEPTH)) u_age_vis  (.idx(vis),  .head(head), .age(vis_age));

  assign safe = (yrot_age < vis_age);
endmodule

// File: rtl/tw_squash_check.sv
// An instruction is squashed when it is at or younger than the flush point.
module tw_squash_check #(
  parameter int ROB_DEPTH = 16,
  localparam int IDX_W = $clog2(ROB_DEPTH)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] flush_idx,
  output logic             squash
);
  logic [IDX_W-1:0] idx_age;
  logic [IDX_W-1:0] flush_age;

  tw_rob_age #(.ROB_DEPTH(ROB_DEPTH)) u_age_own   (.idx(idx),       .head(head), .age(idx_age));
  tw_rob_age #(.ROB_DEPTH(ROB_DEPTH)) u_age_flush (.idx(flush_idx), .head(head), .age(flush_age));

  assign squash = (idx_age >= flush_age);
endmodule

// File: rtl/taint_issue_slot.sv
module taint_issue_slot
  import tw_slot_pkg::*;
#(
  parameter int ROB_DEPTH = 16,
  parameter int PAYLOAD_W = 32,
  localparam int IDX_W = $clog2(ROB_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  output logic                 alloc_ready,
  input  logic [IDX_W-1:0]     alloc_rob_idx,
  input  logic [PAYLOAD_W-1:0] alloc_payload,
  output logic                 issue_valid,
  input  logic                 issue_ready,
  output logic [IDX_W-1:0]     issue_rob_idx,
  output logic [PAYLOAD_W-1:0] issue_payload,
  input  logic                 done_valid,
  input  logic [IDX_W-1:0]     done_rob_idx,
  input  logic                 kill_valid,
  input  logic [IDX_W-1:0]     kill_rob_idx,
  input  logic [IDX_W-1:0]     kill_yrot,
  input  logic [IDX_W-1:0]     rob_head,
  input  logic [IDX_W-1:0]     vis_ptr,
  input  logic                 flush_valid,
  input  logic [IDX_W-1:0]     flush_rob_idx,
  output logic                 slot_wait
);
  slot_state_e          state_q, state_d;
  logic [IDX_W-1:0]     rob_idx_q;
  logic [PAYLOAD_W-1:0] payload_q;
  logic [IDX_W-1:0]     yrot_q;

  logic stored_safe, kill_root_safe, squash;
  logic flush_hit, kill_hit, done_hit, alloc_fire, issue_fire;

  // Safety of the parked root, re-evaluated every cycle against the moving pointers.
  tw_yrot_safe #(.ROB_DEPTH(ROB_DEPTH)) u_safe_stored (
    .yrot(yrot_q), .head(rob_head), .vis(vis_ptr), .safe(stored_safe)
  );

  // Safety of the root delivered with a kill, for the direct return to READY.
  tw_yrot_safe #(.ROB_DEPTH(ROB_DEPTH)) u_safe_incoming (
    .yrot(kill_yrot), .head(rob_head), .vis(vis_ptr), .safe(kill_root_safe)
  );

  tw_squash_check #(.ROB_DEPTH(ROB_DEPTH)) u_squash (
    .idx(rob_idx_q), .head(rob_head), .flush_idx(flush_rob_idx), .squash(squash)
  );

  assign flush_hit  = flush_valid && squash && (state_q != SLOT_EMPTY);
  assign done_hit   = done_valid && (state_q == SLOT_ISSUED) && (done_rob_idx == rob_idx_q);
  assign kill_hit   = kill_valid && (state_q == SLOT_ISSUED) && (kill_rob_idx == rob_idx_q);
  assign alloc_ready = (state_q == SLOT_EMPTY) && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign issue_valid = (state_q == SLOT_READY);
  assign issue_fire  = issue_valid && issue_ready;
  assign issue_rob_idx = rob_idx_q;
  assign issue_payload = payload_q;
  assign slot_wait     = (state_q == SLOT_WAIT);

  // Priority: flush, then completion, then kill, then the normal progressions.
  always_comb begin
    state_d = state_q;
    if (flush_hit) begin
      state_d = SLOT_EMPTY;
    end else begin
      unique case (state_q)
        SLOT_EMPTY:  if (alloc_fire) state_d = SLOT_READY;
        SLOT_READY:  if (issue_fire) state_d = SLOT_ISSUED;
        SLOT_ISSUED: begin
          if (done_hit)      state_d = SLOT_EMPTY;
          else if (kill_hit) state_d = kill_root_safe ? SLOT_READY : SLOT_WAIT;
        end
        SLOT_WAIT:   if (stored_safe) state_d = SLOT_READY;
        default:     state_d = SLOT_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SLOT_EMPTY;
      rob_idx_q <= '0;
      payload_q <= '0;
      yrot_q    <= '0;
    end else begin
      state_q <= state_d;
      if (alloc_fire) begin
        rob_idx_q <= alloc_rob_idx;
        payload_q <= alloc_payload;
      end
      if (kill_hit && !flush_hit && !done_hit) yrot_q <= kill_yrot;
    end
  end

  AST_ALLOC_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> issue_valid && (issue_rob_idx == $past(alloc_rob_idx))); // R2

  AST_ISSUE_TO_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready && !flush_hit |=> (state_q == SLOT_ISSUED)); // R3

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_WAIT) && !stored_safe && !flush_hit |=> (state_q == SLOT_WAIT) && $stable(yrot_q)); // R7

  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_WAIT) && stored_safe && !flush_hit |=> issue_valid && $stable(issue_rob_idx)); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_hit |=> alloc_ready || flush_valid); // R10

  AST_NO_ALLOC_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && (state_q == SLOT_EMPTY) |=> (state_q == SLOT_EMPTY)); // R11
endmodule

// File: tb/test_taint_issue_slot.sv
module test_taint_issue_slot;
  localparam int CLK_PERIOD = 10;
  localparam int ROB_DEPTH  = 16;
  localparam int PAYLOAD_W  = 32;
  localparam int IDX_W      = $clog2(ROB_DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, issue_ready = 1'b0, done_valid = 1'b0;
  logic kill_valid = 1'b0, flush_valid = 1'b0;
  logic [IDX_W-1:0] alloc_rob_idx = '0, done_rob_idx = '0, kill_rob_idx = '0;
  logic [IDX_W-1:0] kill_yrot = '0, rob_head = '0, vis_ptr = '0, flush_rob_idx = '0;
  logic [PAYLOAD_W-1:0] alloc_payload = '0;
  logic alloc_ready, issue_valid, slot_wait;
  logic [IDX_W-1:0] issue_rob_idx;
  logic [PAYLOAD_W-1:0] issue_payload;

  int n_tests = 0;
  int n_fail  = 0;
  logic [IDX_W+PAYLOAD_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  taint_issue_slot #(.ROB_DEPTH(ROB_DEPTH), .PAYLOAD_W(PAYLOAD_W)) i_taint_issue_slot (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_rob_idx(alloc_rob_idx), .alloc_payload(alloc_payload),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_rob_idx(issue_rob_idx), .issue_payload(issue_payload),
    .done_valid(done_valid), .done_rob_idx(done_rob_idx),
    .kill_valid(kill_valid), .kill_rob_idx(kill_rob_idx), .kill_yrot(kill_yrot),
    .rob_head(rob_head), .vis_ptr(vis_ptr),
    .flush_valid(flush_valid), .flush_rob_idx(flush_rob_idx),
    .slot_wait(slot_wait)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nxt(); @(posedge clk); #1; endtask
  task automatic smp(); @(negedge clk); endtask

  // Monitor: every issue transfer must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && issue_valid && issue_ready) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: actual issue %0h/%0h expected none", issue_rob_idx, issue_payload);
      end else begin
        logic [IDX_W+PAYLOAD_W-1:0] e;
        e = exp_q.pop_front();
        if ({issue_rob_idx, issue_payload} !== e) begin
          n_fail++;
          $display("FAIL R2/R8: actual issue %0h expected %0h", {issue_rob_idx, issue_payload}, e);
        end
      end
    end
  end

  // Driver: allocate and record the expected issue.
  task automatic alloc(logic [IDX_W-1:0] idx, logic [PAYLOAD_W-1:0] pl);
    alloc_valid = 1'b1; alloc_rob_idx = idx; alloc_payload = pl;
    nxt();
    alloc_valid = 1'b0;
  endtask

  task automatic grant(logic [IDX_W-1:0] idx, logic [PAYLOAD_W-1:0] pl);
    exp_q.push_back({idx, pl});
    issue_ready = 1'b1;
    nxt();
    issue_ready = 1'b0;
  endtask

  task automatic kill(logic [IDX_W-1:0] idx, logic [IDX_W-1:0] root);
    kill_valid = 1'b1; kill_rob_idx = idx; kill_yrot = root;
    nxt();
    kill_valid = 1'b0;
  endtask

  task automatic flush(logic [IDX_W-1:0] idx);
    flush_valid = 1'b1; flush_rob_idx = idx;
    nxt();
    flush_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1'b1;
    smp();
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 issue_valid", issue_valid, 0);
    chk("R1 slot_wait", slot_wait, 0);

    // R2 / R3: allocate, hold without grant, then issue.
    nxt(); alloc(5, 32'hA5A5_0001);
    smp();
    chk("R2 issue_valid", issue_valid, 1);
    chk("R2 issue_rob_idx", issue_rob_idx, 5);
    nxt(); nxt(); smp();
    chk("R3 held without grant", {issue_valid, issue_rob_idx}, {1'b1, 4'd5});
    nxt(); grant(5, 32'hA5A5_0001);
    smp();
    chk("R3 issued issue_valid", issue_valid, 0);
    chk("R3 issued alloc_ready", alloc_ready, 0);

    // R4: completion matching.
    nxt(); done_valid = 1'b1; done_rob_idx = 6; nxt(); done_valid = 1'b0;
    smp(); chk("R4 mismatch ignored", alloc_ready, 0);
    nxt(); done_valid = 1'b1; done_rob_idx = 5; nxt(); done_valid = 1'b0;
    smp(); chk("R4 match empties", alloc_ready, 1);

    // R5 / R6 / R7 / R8: kill into WAIT, release at visibility point.
    rob_head = 2; vis_ptr = 4;
    nxt(); alloc(7, 32'hB0B0_0002);
    grant(7, 32'hB0B0_0002);
    kill(3, 6);
    smp(); chk("R5 non-matching kill ignored", {slot_wait, issue_valid, alloc_ready}, 3'b000);
    nxt(); kill(7, 6);
    smp(); chk("R5 enter WAIT", {slot_wait, issue_valid}, 2'b10);
    nxt(); nxt(); nxt(); smp();
    chk("R7 held in WAIT", {slot_wait, issue_valid}, 2'b10);
    nxt(); vis_ptr = 6; nxt(); smp();
    chk("R6 equal age not safe", slot_wait, 1);
    nxt(); vis_ptr = 7; nxt(); smp();
    chk("R8 back to READY", {slot_wait, issue_valid}, 2'b01);
    chk("R8 same index", issue_rob_idx, 7);
    nxt(); grant(7, 32'hB0B0_0002);
    done_valid = 1'b1; done_rob_idx = 7; nxt(); done_valid = 1'b0;

    // Wrap-around: head 14, visibility at 1.
    rob_head = 14; vis_ptr = 1;
    alloc(0, 32'hC0C0_0003);
    grant(0, 32'hC0C0_0003);
    kill(0, 15);
    smp(); chk("R9 safe root skips WAIT", {slot_wait, issue_valid}, 2'b01);
    nxt(); grant(0, 32'hC0C0_0003);
    kill(0, 2);
    smp(); chk("R6 wrapped root unsafe", slot_wait, 1);
    nxt(); flush(15);
    smp(); chk("R10 flush from WAIT", {slot_wait, alloc_ready}, 2'b01);

    // R10: older instruction survives, then squashed.
    rob_head = 0; vis_ptr = 0;
    nxt(); alloc(3, 32'hD0D0_0004);
    flush(4);
    smp(); chk("R10 older kept", {issue_valid, issue_rob_idx}, {1'b1, 4'd3});
    nxt(); flush(3);
    smp(); chk("R10 at flush point squashed", {issue_valid, alloc_ready}, 2'b01);

    // R11: allocation blocked during flush.
    nxt();
    flush_valid = 1'b1; flush_rob_idx = 9;
    alloc_valid = 1'b1; alloc_rob_idx = 2; alloc_payload = 32'hE0E0_0005;
    smp(); chk("R11 alloc_ready low in flush", alloc_ready, 0);
    nxt(); flush_valid = 1'b0; alloc_valid = 1'b0;
    smp(); chk("R11 no allocation", {issue_valid, alloc_ready}, 2'b01);

    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule